// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block watches the write side of a parallel flash bus and turns multi-write command sequences into single-cycle command strobes. Each write is presented as a one-cycle strobe with its address and data. The block tracks how far a sequence has progressed and fires one registered strobe when a sequence completes. The strobe carries a command code, the program address and data, or the erase sector. It also keeps a mode register that records whether the device is reading the array, showing identification data, or in the shortened fast-program mode.

Most commands are guarded by two key writes at fixed addresses. Those addresses depend on whether the bus runs in byte or word mode. In word mode the lowest bus bit is word address bit 0. In byte mode one extra bit below it selects the byte, so every address is shifted left by one. The operations themselves are out of this block's scope: programming, erasing, storage and bus timing belong to the surrounding logic, which acts on the strobes. Suspend and resume requests are qualified by flags that this surrounding logic supplies.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After reset `cmd_valid` is 0, `cmd_kind` is 0 and `mode` is 0 (read).
- R2: In word mode the first key is data AAh with address bits 10:0 equal to 555h, and the second key is 55h with bits 10:0 equal to 2AAh. In byte mode the keys use address bits 11:0 equal to AAAh and 555h. Higher address bits are ignored for key and command writes. The command address is the first-key address.
- R3: Program: the two keys, then A0h at the command address, then a fourth write. The fourth write produces `cmd_kind` 3 with `cmd_addr` and `cmd_data` equal to that write's address and full data.
- R4: Chip erase: the two keys, 80h at the command address, the two keys again, then 10h at the command address. This produces `cmd_kind` 4.
- R5: Sector erase: the same five writes as chip erase, then 30h at any address. This produces `cmd_kind` 5. `cmd_sector` is address bits 18:12 in word mode and bits 19:13 in byte mode.
- R6: The two keys, then 90h at the command address, produce `cmd_kind` 2 and set `mode` to 1 (identification).
- R7: A single F0h write at any address produces `cmd_kind` 1 and sets `mode` to 0. This holds at any step outside fast mode except the data write of a program. The two keys followed by F0h at the command address do the same.
- R8: A write that does not match the next step of a sequence returns the decoder to idle and produces no command. The steps already seen are discarded.
- R9: The two keys, then 20h at the command address, produce `cmd_kind` 8 and set `mode` to 2 (fast).
- R10: In fast mode, A0h followed by any write produces a program (`cmd_kind` 3). Then 90h followed by F0h produces `cmd_kind` 9 and sets `mode` to 0. Any other write in fast mode produces nothing and leaves `mode` at 2.
- R11: From idle, a single B0h write produces `cmd_kind` 6 only while `erase_active` is 1. A single 30h write produces `cmd_kind` 7 only while `erase_suspended` is 1. Otherwise these writes produce nothing.
- R12: `cmd_valid` rises in the cycle after the completing write's strobe and lasts one cycle. `mode` changes only in the cycle after a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_stb | input | 1 | One-cycle write strobe; address and data are sampled with it |
| wr_addr | input | ADDR_W (20) | Write address in bus units (bit 0 is the byte select in byte mode) |
| wr_data | input | DATA_W (16) | Write data; commands are decoded from bits 7:0 |
| byte_mode | input | 1 | 1 selects byte-mode key addresses and sector bits |
| erase_active | input | 1 | An erase is running; permits suspend |
| erase_suspended | input | 1 | An erase is suspended; permits resume |
| cmd_valid | output | 1 | One-cycle command strobe |
| cmd_kind | output | 4 | Command code: 1 reset, 2 identify, 3 program, 4 chip erase, 5 sector erase, 6 suspend, 7 resume, 8 fast entry, 9 fast exit |
| cmd_addr | output | ADDR_W (20) | Address of the completing write |
| cmd_data | output | DATA_W (16) | Data of the completing write |
| cmd_sector | output | SECT_W (7) | Sector number of the completing write |
| mode | output | 2 | 0 read, 1 identification, 2 fast |

## Verification
Some properties are checked on every cycle. A command strobe always follows a write strobe. The mode holds still when no write came before. Suspend and resume appear only with their permission flags. Program strobes carry the address and data of the write before them. Fast entry, fast exit and reset leave the mode matching the command. Only program and exit come out of fast mode. Other behaviour needs the bench's sequences: the exact key addresses in each bus width, the address bits that are ignored, the sector extraction, a mismatch discarding earlier steps, and a lone F0h ending a half-finished sequence.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

    typedef enum logic [3:0] {
        CMD_NONE         = 4'd0,
        CMD_READ_RESET   = 4'd1,
        CMD_AUTOSEL      = 4'd2,
        CMD_PROGRAM      = 4'd3,
        CMD_CHIP_ERASE   = 4'd4,
        CMD_SECTOR_ERASE = 4'd5,
        CMD_SUSPEND      = 4'd6,
        CMD_RESUME       = 4'd7,
        CMD_FAST_ENTER   = 4'd8,
        CMD_FAST_EXIT    = 4'd9
    } cmd_e;

    typedef enum logic [1:0] {
        MODE_READ    = 2'd0,
        MODE_AUTOSEL = 2'd1,
        MODE_FAST    = 2'd2
    } mode_e;

    typedef enum logic [3:0] {
        SQ_IDLE,
        SQ_KEY1,
        SQ_KEY2,
        SQ_PROG_DATA,
        SQ_ER_KEY0,
        SQ_ER_KEY1,
        SQ_ER_FINAL,
        SQ_FAST_IDLE,
        SQ_FAST_DATA,
        SQ_FAST_LEAVE
    } seq_e;

    typedef struct packed {
        logic valid;
        cmd_e kind;
    } fire_t;

    localparam logic [7:0] OP_KEY_A   = 8'hAA;
    localparam logic [7:0] OP_KEY_B   = 8'h55;
    localparam logic [7:0] OP_RESET   = 8'hF0;
    localparam logic [7:0] OP_IDENT   = 8'h90;
    localparam logic [7:0] OP_PROG    = 8'hA0;
    localparam logic [7:0] OP_ER_SET  = 8'h80;
    localparam logic [7:0] OP_CHIP    = 8'h10;
    localparam logic [7:0] OP_SECTOR  = 8'h30;
    localparam logic [7:0] OP_SUSPEND = 8'hB0;
    localparam logic [7:0] OP_RESUME  = 8'h30;
    localparam logic [7:0] OP_FAST    = 8'h20;

    localparam int KEY_W = 11;
    localparam logic [KEY_W-1:0] WORD_KEY_HI = 11'h555;
    localparam logic [KEY_W-1:0] WORD_KEY_LO = 11'h2AA;

    function automatic logic in_fast(input seq_e s);
        return (s == SQ_FAST_IDLE) || (s == SQ_FAST_DATA) || (s == SQ_FAST_LEAVE);
    endfunction

    function automatic mode_e mode_after(input cmd_e k, input mode_e cur);
        case (k)
            CMD_READ_RESET, CMD_FAST_EXIT: return MODE_READ;
            CMD_AUTOSEL:                   return MODE_AUTOSEL;
            CMD_FAST_ENTER:                return MODE_FAST;
            default:                       return cur;
        endcase
    endfunction

endpackage

// File: rtl/fcd_addr_match.sv
module fcd_addr_match
    import flash_cmd_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int SECT_W = 7
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              byte_mode,
    output logic              hit_key1,
    output logic              hit_key2,
    output logic [SECT_W-1:0] sector
);
    localparam int BKEY_W = KEY_W + 1;
    localparam logic [BKEY_W-1:0] BYTE_KEY_HI = {WORD_KEY_HI, 1'b0};
    localparam logic [BKEY_W-1:0] BYTE_KEY_LO = {WORD_KEY_LO, 1'b1};

    logic word_hi, word_lo, byte_hi, byte_lo;

    always_comb begin
        word_hi = (addr[KEY_W-1:0]  == WORD_KEY_HI);
        word_lo = (addr[KEY_W-1:0]  == WORD_KEY_LO);
        byte_hi = (addr[BKEY_W-1:0] == BYTE_KEY_HI);
        byte_lo = (addr[BKEY_W-1:0] == BYTE_KEY_LO);
        hit_key1 = byte_mode ? byte_hi : word_hi;
        hit_key2 = byte_mode ? byte_lo : word_lo;
        sector   = byte_mode ? addr[ADDR_W-1 -: SECT_W] : addr[ADDR_W-2 -: SECT_W];
    end
endmodule

// File: rtl/fcd_seq_fsm.sv
module fcd_seq_fsm
    import flash_cmd_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_stb,
    input  logic [7:0] op,
    input  logic       hit_key1,
    input  logic       hit_key2,
    input  logic       erase_active,
    input  logic       erase_suspended,
    output fire_t      fire
);
    seq_e state, state_nx;

    always_ff @(posedge clk) begin
        if (rst) state <= SQ_IDLE;
        else     state <= state_nx;
    end

    always_comb begin
        state_nx   = state;
        fire.valid = 1'b0;
        fire.kind  = CMD_NONE;
        if (wr_stb) begin
            if (!in_fast(state) && state != SQ_PROG_DATA && op == OP_RESET) begin
                fire.valid = 1'b1;
                fire.kind  = CMD_READ_RESET;
                state_nx   = SQ_IDLE;
            end else begin
                case (state)
                    SQ_IDLE: begin
                        state_nx = SQ_IDLE;
                        if (op == OP_KEY_A && hit_key1) begin
                            state_nx = SQ_KEY1;
                        end else if (op == OP_SUSPEND && erase_active) begin
                            fire.valid = 1'b1;
                            fire.kind  = CMD_SUSPEND;
                        end else if (op == OP_RESUME && erase_suspended) begin
                            fire.valid = 1'b1;
                            fire.kind  = CMD_RESUME;
                        end
                    end
                    SQ_KEY1:
                        state_nx = (op == OP_KEY_B && hit_key2) ? SQ_KEY2 : SQ_IDLE;
                    SQ_KEY2: begin
                        state_nx = SQ_IDLE;
                        if (hit_key1) begin
                            case (op)
                                OP_IDENT: begin
                                    fire.valid = 1'b1;
                                    fire.kind  = CMD_AUTOSEL;
                                end
                                OP_PROG:   state_nx = SQ_PROG_DATA;
                                OP_ER_SET: state_nx = SQ_ER_KEY0;
                                OP_FAST: begin
                                    fire.valid = 1'b1;
                                    fire.kind  = CMD_FAST_ENTER;
                                    state_nx   = SQ_FAST_IDLE;
                                end
                                default: state_nx = SQ_IDLE;
                            endcase
                        end
                    end
                    SQ_PROG_DATA: begin
                        fire.valid = 1'b1;
                        fire.kind  = CMD_PROGRAM;
                        state_nx   = SQ_IDLE;
                    end
                    SQ_ER_KEY0:
                        state_nx = (op == OP_KEY_A && hit_key1) ? SQ_ER_KEY1 : SQ_IDLE;
                    SQ_ER_KEY1:
                        state_nx = (op == OP_KEY_B && hit_key2) ? SQ_ER_FINAL : SQ_IDLE;
                    SQ_ER_FINAL: begin
                        state_nx = SQ_IDLE;
                        if (op == OP_CHIP && hit_key1) begin
                            fire.valid = 1'b1;
                            fire.kind  = CMD_CHIP_ERASE;
                        end else if (op == OP_SECTOR) begin
                            fire.valid = 1'b1;
                            fire.kind  = CMD_SECTOR_ERASE;
                        end
                    end
                    SQ_FAST_IDLE: begin
                        if (op == OP_PROG)       state_nx = SQ_FAST_DATA;
                        else if (op == OP_IDENT) state_nx = SQ_FAST_LEAVE;
                        else                     state_nx = SQ_FAST_IDLE;
                    end
                    SQ_FAST_DATA: begin
                        fire.valid = 1'b1;
                        fire.kind  = CMD_PROGRAM;
                        state_nx   = SQ_FAST_IDLE;
                    end
                    SQ_FAST_LEAVE: begin
                        if (op == OP_RESET) begin
                            fire.valid = 1'b1;
                            fire.kind  = CMD_FAST_EXIT;
                            state_nx   = SQ_IDLE;
                        end else begin
                            state_nx = SQ_FAST_IDLE;
                        end
                    end
                    default: state_nx = SQ_IDLE;
                endcase
            end
        end
    end
endmodule

// File: rtl/fcd_out_reg.sv
module fcd_out_reg
    import flash_cmd_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int DATA_W = 16,
    parameter int SECT_W = 7
) (
    input  logic              clk,
    input  logic              rst,
    input  fire_t             fire,
    input  logic [ADDR_W-1:0] in_addr,
    input  logic [DATA_W-1:0] in_data,
    input  logic [SECT_W-1:0] in_sector,
    output logic              cmd_valid,
    output cmd_e              cmd_kind,
    output logic [ADDR_W-1:0] cmd_addr,
    output logic [DATA_W-1:0] cmd_data,
    output logic [SECT_W-1:0] cmd_sector,
    output mode_e             mode
);
    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_valid  <= 1'b0;
            cmd_kind   <= CMD_NONE;
            cmd_addr   <= '0;
            cmd_data   <= '0;
            cmd_sector <= '0;
            mode       <= MODE_READ;
        end else begin
            cmd_valid <= fire.valid;
            if (fire.valid) begin
                cmd_kind   <= fire.kind;
                cmd_addr   <= in_addr;
                cmd_data   <= in_data;
                cmd_sector <= in_sector;
                mode       <= mode_after(fire.kind, mode);
            end
        end
    end
endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
    import flash_cmd_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int DATA_W = 16,
    parameter int SECT_W = 7
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_stb,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              byte_mode,
    input  logic              erase_active,
    input  logic              erase_suspended,
    output logic              cmd_valid,
    output logic [3:0]        cmd_kind,
    output logic [ADDR_W-1:0] cmd_addr,
    output logic [DATA_W-1:0] cmd_data,
    output logic [SECT_W-1:0] cmd_sector,
    output logic [1:0]        mode
);
    logic              hit_key1, hit_key2;
    logic [SECT_W-1:0] sector;
    fire_t             fire;
    cmd_e              kind_q;
    mode_e             mode_q;

    fcd_addr_match #(.ADDR_W(ADDR_W), .SECT_W(SECT_W)) u_match (
        .addr      (wr_addr),
        .byte_mode (byte_mode),
        .hit_key1  (hit_key1),
        .hit_key2  (hit_key2),
        .sector    (sector)
    );

    fcd_seq_fsm u_fsm (
        .clk             (clk),
        .rst             (rst),
        .wr_stb          (wr_stb),
        .op              (wr_data[7:0]),
        .hit_key1        (hit_key1),
        .hit_key2        (hit_key2),
        .erase_active    (erase_active),
        .erase_suspended (erase_suspended),
        .fire            (fire)
    );

    fcd_out_reg #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SECT_W(SECT_W)) u_out (
        .clk        (clk),
        .rst        (rst),
        .fire       (fire),
        .in_addr    (wr_addr),
        .in_data    (wr_data),
        .in_sector  (sector),
        .cmd_valid  (cmd_valid),
        .cmd_kind   (kind_q),
        .cmd_addr   (cmd_addr),
        .cmd_data   (cmd_data),
        .cmd_sector (cmd_sector),
        .mode       (mode_q)
    );

    assign cmd_kind = kind_q;
    assign mode     = mode_q;
endmodule

// File: rtl/flash_cmd_decoder_chk.sv
module flash_cmd_decoder_chk #(
    parameter int ADDR_W = 20,
    parameter int DATA_W = 16,
    parameter int SECT_W = 7
) (
    input logic              clk,
    input logic              rst,
    input logic              wr_stb,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [DATA_W-1:0] wr_data,
    input logic              erase_active,
    input logic              erase_suspended,
    input logic              cmd_valid,
    input logic [3:0]        cmd_kind,
    input logic [ADDR_W-1:0] cmd_addr,
    input logic [DATA_W-1:0] cmd_data,
    input logic [1:0]        mode
);
    // R12: a command strobe only follows a write strobe
    a_r12_valid_follows_write: assert property (@(posedge clk) disable iff (rst)
        cmd_valid |-> $past(wr_stb));

    // R12: mode changes only after a write
    a_r12_mode_holds: assert property (@(posedge clk) disable iff (rst)
        !wr_stb |=> $stable(mode));

    // R11: suspend needs an active erase
    a_r11_suspend_gated: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_kind == 4'd6) |-> $past(erase_active));

    // R11: resume needs a suspended erase
    a_r11_resume_gated: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_kind == 4'd7) |-> $past(erase_suspended));

    // R3: program strobe carries the completing write
    a_r3_program_payload: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_kind == 4'd3) |-> (cmd_addr == $past(wr_addr) && cmd_data == $past(wr_data)));

    // R9: fast entry leaves mode fast
    a_r9_fast_mode_set: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_kind == 4'd8) |-> mode == 2'd2);

    // R7: reset and fast exit leave mode read
    a_r7_read_mode_set: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && (cmd_kind == 4'd1 || cmd_kind == 4'd9)) |-> mode == 2'd0);

    // R10: only program or exit come out of fast mode
    a_r10_fast_cmds: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && $past(mode) == 2'd2) |-> (cmd_kind == 4'd3 || cmd_kind == 4'd9));

    // R1: mode never takes the unused code
    a_r1_mode_legal: assert property (@(posedge clk) disable iff (rst)
        mode != 2'd3);
endmodule

bind flash_cmd_decoder flash_cmd_decoder_chk #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SECT_W(SECT_W)
) u_chk (
    .clk             (clk),
    .rst             (rst),
    .wr_stb          (wr_stb),
    .wr_addr         (wr_addr),
    .wr_data         (wr_data),
    .erase_active    (erase_active),
    .erase_suspended (erase_suspended),
    .cmd_valid       (cmd_valid),
    .cmd_kind        (cmd_kind),
    .cmd_addr        (cmd_addr),
    .cmd_data        (cmd_data),
    .mode            (mode)
);

// File: tb/test_flash_cmd_decoder.sv
module test_flash_cmd_decoder;
    localparam int AW = 20;
    localparam int DW = 16;
    localparam int SW = 7;

    localparam logic [3:0] K_RST = 4'd1, K_ID = 4'd2, K_PRG = 4'd3, K_CHIP = 4'd4,
                           K_SEC = 4'd5, K_SUS = 4'd6, K_RES = 4'd7, K_FIN = 4'd8, K_FOUT = 4'd9;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          wr_stb = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [DW-1:0] wr_data = '0;
    logic          byte_mode = 1'b0;
    logic          erase_active = 1'b0;
    logic          erase_suspended = 1'b0;
    logic          cmd_valid;
    logic [3:0]    cmd_kind;
    logic [AW-1:0] cmd_addr;
    logic [DW-1:0] cmd_data;
    logic [SW-1:0] cmd_sector;
    logic [1:0]    mode;

    int checks = 0;
    int failures = 0;

    always #4 clk = ~clk;

    flash_cmd_decoder i_flash_cmd_decoder (
        .clk(clk), .rst(rst), .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_data(wr_data),
        .byte_mode(byte_mode), .erase_active(erase_active), .erase_suspended(erase_suspended),
        .cmd_valid(cmd_valid), .cmd_kind(cmd_kind), .cmd_addr(cmd_addr), .cmd_data(cmd_data),
        .cmd_sector(cmd_sector), .mode(mode)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // one write strobe; outputs are sampled at the following falling edge
    task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        wr_stb = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_stb = 1'b0;
    endtask

    function automatic logic [AW-1:0] key1();
        return byte_mode ? 20'hAAA : 20'h555;
    endfunction
    function automatic logic [AW-1:0] key2();
        return byte_mode ? 20'h555 : 20'h2AA;
    endfunction

    task automatic keys();
        wr(key1(), 16'h00AA); chk("R8 no cmd on key", {31'd0, cmd_valid}, 0);
        wr(key2(), 16'h0055); chk("R8 no cmd on key", {31'd0, cmd_valid}, 0);
    endtask

    task automatic expect_cmd(input string tag, input logic [3:0] k);
        chk({tag, " valid"}, {31'd0, cmd_valid}, 1);
        chk({tag, " kind"}, {28'd0, cmd_kind}, {28'd0, k});
    endtask

    task automatic t_reset();
        chk("R1 valid", {31'd0, cmd_valid}, 0);
        chk("R1 kind", {28'd0, cmd_kind}, 0);
        chk("R1 mode", {30'd0, mode}, 0);
    endtask

    task automatic t_program(input logic bm, input logic [AW-1:0] pa, input logic [DW-1:0] pd);
        byte_mode = bm;
        keys();
        wr(key1(), 16'h00A0); chk("R3 no cmd on A0", {31'd0, cmd_valid}, 0);
        wr(pa, pd);
        expect_cmd("R3 R2 program", K_PRG);
        chk("R3 addr", {12'd0, cmd_addr}, {12'd0, pa});
        chk("R3 data", {16'd0, cmd_data}, {16'd0, pd});
        @(negedge clk);
        chk("R12 one-cycle strobe", {31'd0, cmd_valid}, 0);
    endtask

    task automatic t_dontcare();
        byte_mode = 1'b0;
        wr(20'h7F555, 16'h00AA);
        wr(20'h3AAAA, 16'h0055);
        wr(20'h1E555, 16'h0090);
        expect_cmd("R2 R6 high bits ignored", K_ID);
        chk("R6 mode ident", {30'd0, mode}, 1);
        wr(20'h00123, 16'h00F0);
        expect_cmd("R7 single reset", K_RST);
        chk("R7 mode read", {30'd0, mode}, 0);
        // word-mode keys while in byte mode are not keys
        byte_mode = 1'b1;
        wr(20'h555, 16'h00AA);
        wr(20'h2AA, 16'h0055);
        wr(20'h555, 16'h0090);
        chk("R2 wrong width keys ignored", {31'd0, cmd_valid}, 0);
        chk("R2 mode unchanged", {30'd0, mode}, 0);
    endtask

    task automatic t_erase(input logic bm, input logic chip, input logic [AW-1:0] sa, input logic [SW-1:0] exp_sec);
        byte_mode = bm;
        keys();
        wr(key1(), 16'h0080);
        keys();
        if (chip) begin
            wr(key1(), 16'h0010);
            expect_cmd("R4 chip erase", K_CHIP);
        end else begin
            wr(sa, 16'h0030);
            expect_cmd("R5 sector erase", K_SEC);
            chk("R5 sector", {25'd0, cmd_sector}, {25'd0, exp_sec});
        end
    endtask

    task automatic t_reset_cmds();
        byte_mode = 1'b0;
        keys();
        wr(key1(), 16'h0080);
        wr(key1(), 16'h00AA);
        wr(20'h4321, 16'h00F0);
        expect_cmd("R7 reset mid sequence", K_RST);
        // sequence discarded: the next 30h is not a sector erase
        wr(20'h5A000, 16'h0030);
        chk("R7 sequence discarded", {31'd0, cmd_valid}, 0);
        keys();
        wr(key1(), 16'h00F0);
        expect_cmd("R7 keyed reset", K_RST);
    endtask

    task automatic t_mismatch();
        byte_mode = 1'b0;
        keys();
        wr(key1(), 16'h0077);
        chk("R8 bad opcode no cmd", {31'd0, cmd_valid}, 0);
        wr(key1(), 16'h00A0);
        chk("R8 A0 alone no cmd", {31'd0, cmd_valid}, 0);
        wr(20'h01234, 16'h1234);
        chk("R8 no program", {31'd0, cmd_valid}, 0);
        wr(20'h554, 16'h00AA);
        wr(key2(), 16'h0055);
        wr(key1(), 16'h0090);
        chk("R8 wrong key address", {31'd0, cmd_valid}, 0);
        chk("R8 mode stays", {30'd0, mode}, 0);
    endtask

    task automatic t_fast();
        byte_mode = 1'b0;
        keys();
        wr(key1(), 16'h0020);
        expect_cmd("R9 fast entry", K_FIN);
        chk("R9 mode fast", {30'd0, mode}, 2);
        wr(20'h00000, 16'h00A0);
        chk("R10 no cmd on A0", {31'd0, cmd_valid}, 0);
        wr(20'h2BEEF, 16'hC0DE);
        expect_cmd("R10 fast program", K_PRG);
        chk("R10 addr", {12'd0, cmd_addr}, 32'h2BEEF);
        chk("R10 data", {16'd0, cmd_data}, 32'hC0DE);
        wr(20'h00010, 16'h00F0);
        chk("R10 lone F0 ignored", {31'd0, cmd_valid}, 0);
        chk("R10 mode still fast", {30'd0, mode}, 2);
        wr(key1(), 16'h00AA);
        chk("R10 key ignored", {31'd0, cmd_valid}, 0);
        wr(20'h00000, 16'h0090);
        chk("R10 no cmd on 90", {31'd0, cmd_valid}, 0);
        wr(20'h00000, 16'h00F0);
        expect_cmd("R10 fast exit", K_FOUT);
        chk("R10 mode read", {30'd0, mode}, 0);
    endtask

    task automatic t_suspend();
        byte_mode = 1'b0;
        erase_active = 1'b0; erase_suspended = 1'b0;
        wr(20'h00100, 16'h00B0);
        chk("R11 suspend blocked", {31'd0, cmd_valid}, 0);
        wr(20'h00100, 16'h0030);
        chk("R11 resume blocked", {31'd0, cmd_valid}, 0);
        erase_active = 1'b1;
        wr(20'h00100, 16'h00B0);
        expect_cmd("R11 suspend", K_SUS);
        erase_active = 1'b0; erase_suspended = 1'b1;
        wr(20'h00100, 16'h0030);
        expect_cmd("R11 resume", K_RES);
        erase_suspended = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_program(1'b0, 20'h3A5C2, 16'hBEEF);
        t_program(1'b1, 20'hF1235, 16'h005A);
        t_dontcare();
        t_erase(1'b0, 1'b1, '0, '0);
        t_erase(1'b0, 1'b0, 20'h5A000, 7'h5A);
        t_erase(1'b1, 1'b0, 20'hB4000, 7'h5A);
        t_reset_cmds();
        t_mismatch();
        t_fast();
        t_suspend();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule